// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block sits on the programmer side of an in-system programming link. After its own reset it holds the target's reset line and serial clock low for a settle interval, then shifts a four-byte programming-enable frame out over an SPI-style link (mode 0, most significant bit first). The SPI bit clock is divided down from the host clock. While the frame is shifted, the bytes that come back from the target are collected. The enable is accepted when the third returned byte equals the sync value 0x53.

If the echo is wrong, the sequencer keeps the serial clock low, gives the target reset a positive pulse and sends the enable frame again. After a set number of failed attempts it stops and raises a sticky failure flag.

Once synchronized, the sequencer reports ready and accepts 32-bit command frames on a valid/ready request port. It shifts each frame out to the target and returns the 32 bits received during that frame as a one-cycle response.

Top module: `isp_entry_seq`

## Requirements
- R1: After reset `tgt_rst_o`, `sck_o`, `ready_o`, `fail_o` and `req_ready_o` are 0. `tgt_rst_o` and `sck_o` stay 0 for at least SETTLE_CYC host cycles after reset is released, before the first rising edge of `sck_o`.
- R2: The enable frame is 32'hAC53_0000, sent most significant bit first. `mosi_o` changes only while `sck_o` is low, so the target samples a stable bit on each rising edge.
- R3: Each high phase and each low phase of `sck_o` inside a frame lasts exactly SCK_HALF host cycles. There is no gap between bytes.
- R4: `miso_i` is sampled on each rising edge of `sck_o`, and the first sampled bit lands in bit 31 of the received word. When bits 15:8 (the third byte) of the word received during an enable frame equal 8'h53, `ready_o` goes to 1 and `fail_o` stays 0.
- R5: When the echo does not match, `tgt_rst_o` is driven 1 for exactly RST_PULSE_CYC host cycles while `sck_o` stays 0. The enable frame is then sent again.
- R6: After MAX_TRIES failed enable attempts (so MAX_TRIES-1 reset pulses), `fail_o` goes to 1 and stays 1 until reset. From then on `ready_o` and `req_ready_o` stay 0, and `sck_o` and `tgt_rst_o` stay 0.
- R7: `req_ready_o` is 1 only while the block is synchronized and no frame is in flight. A request offered before sync is ignored: no frame other than the enable frame is shifted out, and no response is produced.
- R8: An accepted request frame is shifted out most significant bit first. When its 32nd bit completes, `rsp_valid_o` pulses for one cycle with `rsp_frame_o` holding the 32 bits received during that frame (first bit in bit 31).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the power-up sequence |
| tgt_rst_o | output | 1 | Target reset line; 0 holds the target in programming entry, 1 is a retry pulse |
| sck_o | output | 1 | Serial clock to the target, idle low |
| mosi_o | output | 1 | Serial data to the target |
| miso_i | input | 1 | Serial data from the target |
| ready_o | output | 1 | Target synchronized, command frames may be issued |
| fail_o | output | 1 | Sticky flag: all enable attempts failed |
| req_valid_i | input | 1 | Command frame offered |
| req_ready_o | output | 1 | Command frame accepted this cycle when valid |
| req_frame_i | input | 32 | Command frame, byte 1 in bits 31:24 |
| rsp_valid_o | output | 1 | One-cycle pulse: response word valid |
| rsp_frame_o | output | 32 | Bits received during the last command frame |

## Verification
The bench builds the block with SETTLE_CYC=200, RST_PULSE_CYC=6, SCK_HALF=3 and MAX_TRIES=4. This makes each enable frame about 200 host cycles long, so every scenario finishes in a few thousand cycles. The short settle window lets the bench measure the delay to the first clock edge exactly. With only four attempts allowed, running out of retries to the sticky failure is reached in a short run, and a target model that stays out of sync for two attempts shows two full-width reset pulses before sync.

// File: rtl/isp_pkg.sv
// Package isp_pkg
// Shared constants and the sequencer state type for the serial programming
// entry sequencer. Assumes frames are whole bytes.
package isp_pkg;
    localparam int FRAME_W = 32;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        ST_POWER  = 3'd0,
        ST_ENABLE = 3'd1,
        ST_PULSE  = 3'd2,
        ST_READY  = 3'd3,
        ST_CMD    = 3'd4,
        ST_FAIL   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/isp_sck_gen.sv
// Module isp_sck_gen
// Half-period tick generator for the serial clock. While en is high it emits
// a one-cycle tick every HALF host cycles. The count restarts whenever en is
// low. Assumes HALF >= 1.
module isp_sck_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = en && (cnt == CNT_W'(HALF - 1));

    // Count host cycles inside the current serial clock half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/isp_shifter.sv
// Module isp_shifter
// SPI mode 0 frame shifter, most significant bit first. A start pulse while
// idle loads the frame. MOSI shows the current bit through the low phase.
// MISO is sampled when SCK rises, and the next bit is presented when SCK
// falls. done pulses for one cycle after the last falling edge, with rx_frame
// valid in that same cycle. Assumes start is only issued while not busy.
module isp_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_frame,
    input  logic               tick,
    input  logic               miso_i,
    output logic               busy,
    output logic               sck_o,
    output logic               mosi_o,
    output logic               done,
    output logic [FRAME_W-1:0] rx_frame
);
    localparam int BIT_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] tx_q;
    logic [BIT_W-1:0]   bit_q;

    assign mosi_o = busy & tx_q[FRAME_W-1];

    // Walk the frame through low and high phases, one bit per clock period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sck_o    <= 1'b0;
            done     <= 1'b0;
            tx_q     <= '0;
            rx_frame <= '0;
            bit_q    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tx_q  <= tx_frame;
                    bit_q <= '0;
                end
            end else if (tick) begin
                if (!sck_o) begin
                    sck_o    <= 1'b1;
                    rx_frame <= {rx_frame[FRAME_W-2:0], miso_i};
                end else begin
                    sck_o <= 1'b0;
                    if (bit_q == BIT_W'(FRAME_W - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/isp_countdown.sv
// Module isp_countdown
// Loadable down counter for the settle window and the reset pulse. It starts
// at INIT out of reset and stops at zero. zero is high while the count is 0.
// A load takes priority over counting.
module isp_countdown #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    // Reload on request, otherwise step down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(INIT);
        end else if (load) begin
            cnt <= load_val;
        end else if (!zero) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/isp_entry_seq.sv
// Module isp_entry_seq
// Programmer-side entry sequencer. After rst_n it holds target reset and SCK
// low for SETTLE_CYC cycles, then sends the enable frame. It checks the third
// returned byte against the sync value. On a mismatch it pulses target reset
// for RST_PULSE_CYC cycles and retries, up to MAX_TRIES attempts in total.
// Once synchronized it passes 32-bit command frames from the request port to
// the target and returns the received words. Assumes SCK_HALF host cycles
// span more than two target clock periods, and SETTLE_CYC, RST_PULSE_CYC >= 1.
module isp_entry_seq
    import isp_pkg::*;
#(
    parameter int          SETTLE_CYC    = 2_000_000,
    parameter int          RST_PULSE_CYC = 16,
    parameter int          SCK_HALF      = 8,
    parameter int          MAX_TRIES     = 32,
    parameter logic [31:0] EN_FRAME      = 32'hAC53_0000,
    parameter logic [7:0]  SYNC_BYTE     = 8'h53
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        tgt_rst_o,
    output logic        sck_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic        ready_o,
    output logic        fail_o,
    input  logic        req_valid_i,
    output logic        req_ready_o,
    input  logic [31:0] req_frame_i,
    output logic        rsp_valid_o,
    output logic [31:0] rsp_frame_o
);
    localparam int TMR_MAX  = (SETTLE_CYC > RST_PULSE_CYC) ? SETTLE_CYC : RST_PULSE_CYC;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int TRY_W    = $clog2(MAX_TRIES + 1);
    localparam int ECHO_LSB = FRAME_W - 3 * BYTE_W;

    seq_state_t         state_q, state_d;
    logic [TRY_W-1:0]   fails_q;
    logic               fail_inc;
    logic               tmr_load, tmr_zero;
    logic               spi_start, spi_busy, spi_done, tick;
    logic [FRAME_W-1:0] spi_rx;
    logic [FRAME_W-1:0] start_frame;
    logic               echo_ok;

    assign start_frame = (state_q == ST_READY) ? req_frame_i : EN_FRAME;
    assign echo_ok     = (spi_rx[ECHO_LSB +: BYTE_W] == SYNC_BYTE);

    isp_countdown #(
        .W    (TMR_W),
        .INIT (SETTLE_CYC - 1)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (TMR_W'(RST_PULSE_CYC - 1)),
        .zero     (tmr_zero)
    );

    isp_sck_gen #(
        .HALF (SCK_HALF)
    ) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (spi_busy),
        .tick  (tick)
    );

    isp_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (spi_start),
        .tx_frame (start_frame),
        .tick     (tick),
        .miso_i   (miso_i),
        .busy     (spi_busy),
        .sck_o    (sck_o),
        .mosi_o   (mosi_o),
        .done     (spi_done),
        .rx_frame (spi_rx)
    );

    // Next-state and control decode of the entry sequence.
    always_comb begin
        state_d   = state_q;
        spi_start = 1'b0;
        tmr_load  = 1'b0;
        fail_inc  = 1'b0;
        case (state_q)
            ST_POWER, ST_PULSE: begin
                if (tmr_zero) begin
                    spi_start = 1'b1;
                    state_d   = ST_ENABLE;
                end
            end
            ST_ENABLE: begin
                if (spi_done) begin
                    if (echo_ok) begin
                        state_d = ST_READY;
                    end else if (fails_q == TRY_W'(MAX_TRIES - 1)) begin
                        state_d = ST_FAIL;
                    end else begin
                        fail_inc = 1'b1;
                        tmr_load = 1'b1;
                        state_d  = ST_PULSE;
                    end
                end
            end
            ST_READY: begin
                if (req_valid_i) begin
                    spi_start = 1'b1;
                    state_d   = ST_CMD;
                end
            end
            ST_CMD: begin
                if (spi_done) begin
                    state_d = ST_READY;
                end
            end
            default: state_d = ST_FAIL;
        endcase
    end

    // State, failed-attempt count and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_POWER;
            fails_q     <= '0;
            rsp_valid_o <= 1'b0;
            rsp_frame_o <= '0;
        end else begin
            state_q     <= state_d;
            rsp_valid_o <= (state_q == ST_CMD) && spi_done;
            if (fail_inc) begin
                fails_q <= fails_q + 1'b1;
            end
            if ((state_q == ST_CMD) && spi_done) begin
                rsp_frame_o <= spi_rx;
            end
        end
    end

    assign tgt_rst_o   = (state_q == ST_PULSE);
    assign ready_o     = (state_q == ST_READY) || (state_q == ST_CMD);
    assign fail_o      = (state_q == ST_FAIL);
    assign req_ready_o = (state_q == ST_READY);
endmodule

// File: rtl/isp_entry_seq_chk.sv
// Module isp_entry_seq_chk
// Property checker for isp_entry_seq, bound to every instance. It watches only
// ports and keeps its own run-length counters.
module isp_entry_seq_chk #(
    parameter int SETTLE_CYC = 2_000_000,
    parameter int SCK_HALF   = 8
) (
    input logic clk,
    input logic rst_n,
    input logic tgt_rst_o,
    input logic sck_o,
    input logic mosi_o,
    input logic ready_o,
    input logic fail_o,
    input logic req_ready_o,
    input logic rsp_valid_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int HW = $clog2(SCK_HALF + 2);

    logic [SW-1:0] since_rst;
    logic [HW-1:0] hi_run;

    // Saturating count of cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != SW'(SETTLE_CYC)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // Number of consecutive earlier cycles with SCK high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (sck_o && hi_run != HW'(SCK_HALF + 1)) begin
            hi_run <= hi_run + 1'b1;
        end else if (!sck_o) begin
            hi_run <= '0;
        end
    end

    assert_settle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != SW'(SETTLE_CYC)) |-> (!sck_o && !tgt_rst_o));

    assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    assert_sck_high_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> (hi_run < HW'(SCK_HALF)));

    assert_sck_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> (hi_run == HW'(SCK_HALF)));

    assert_ready_fail_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && fail_o));

    assert_sck_low_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst_o |-> !sck_o);

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> (fail_o && !sck_o && !tgt_rst_o && !req_ready_o));

    assert_req_ready_synced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> ready_o);

    assert_rsp_synced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ready_o);
endmodule

bind isp_entry_seq isp_entry_seq_chk #(
    .SETTLE_CYC (SETTLE_CYC),
    .SCK_HALF   (SCK_HALF)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_rst_o   (tgt_rst_o),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .ready_o     (ready_o),
    .fail_o      (fail_o),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o)
);

// File: tb/tb_isp_entry_seq.sv
// Directed bench for isp_entry_seq, with a behavioural target model. When in
// sync, the model returns during each byte the byte it received before.
module tb_isp_entry_seq;
    localparam int SETTLE = 200;
    localparam int PULSE  = 6;
    localparam int HALF   = 3;
    localparam int TRIES  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_rst_o, sck_o, mosi_o, miso_i;
    logic        ready_o, fail_o, req_ready_o, rsp_valid_o;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_frame_i = '0;
    logic [31:0] rsp_frame_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    isp_entry_seq #(
        .SETTLE_CYC    (SETTLE),
        .RST_PULSE_CYC (PULSE),
        .SCK_HALF      (HALF),
        .MAX_TRIES     (TRIES)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tgt_rst_o   (tgt_rst_o),
        .sck_o       (sck_o),
        .mosi_o      (mosi_o),
        .miso_i      (miso_i),
        .ready_o     (ready_o),
        .fail_o      (fail_o),
        .req_ready_o (req_ready_o),
        .req_frame_i (req_frame_i),
        .req_valid_i (req_valid_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_frame_o (rsp_frame_o)
    );

    // Target model state.
    logic [7:0]  t_rx = '0;
    logic [7:0]  t_tx = '0;
    int          t_bit = 0;
    int          pulses = 0;
    int          pulse_base = 0;
    int          bad_n = 0;
    logic [31:0] frm_sh = '0;
    int          frm_bits = 0;
    int          frm_cnt = 0;
    logic [31:0] frames [64];

    assign miso_i = t_tx[7];

    // Target sampling on rising SCK and frame capture of MOSI.
    always @(posedge sck_o) begin
        t_rx   = {t_rx[6:0], mosi_o};
        frm_sh = {frm_sh[30:0], mosi_o};
        frm_bits++;
        if (frm_bits == 32) begin
            frames[frm_cnt % 64] = frm_sh;
            frm_cnt++;
            frm_bits = 0;
        end
    end

    // Target shifting on falling SCK; a reset pulse clears it.
    always @(negedge sck_o or posedge tgt_rst_o) begin
        if (tgt_rst_o) begin
            pulses++;
            t_bit = 0;
            t_tx  = '0;
        end else if (!rst_n) begin
            t_bit = 0;
            t_tx  = '0;
        end else begin
            t_bit++;
            if (t_bit == 8) begin
                t_bit = 0;
                t_tx  = ((pulses - pulse_base) >= bad_n) ? t_rx : 8'h00;
            end else begin
                t_tx = {t_tx[6:0], 1'b0};
            end
        end
    end

    // Port monitors sampled away from the active edge.
    int   cyc = 0, first_rise = -1, sck_rises = 0, rsp_cnt = 0;
    int   hi_run = 0, lo_run = 0, min_hi = 1000, max_hi = 0, min_lo = 1000;
    logic lo_bounded = 1'b0, prev_sck = 1'b0, prev_rst = 1'b0;
    int   rst_run = 0, bad_pulse_w = 0, rst_sck_clash = 0;
    logic [31:0] last_rsp = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; first_rise = -1; lo_bounded = 1'b0;
            prev_sck = 1'b0; prev_rst = 1'b0; hi_run = 0; lo_run = 0; rst_run = 0;
        end else begin
            cyc++;
            if (sck_o && !prev_sck) begin
                sck_rises++;
                if (first_rise < 0) first_rise = cyc;
                if (lo_bounded && lo_run < min_lo) min_lo = lo_run;
                hi_run = 0;
            end
            if (!sck_o && prev_sck) begin
                if (hi_run < min_hi) min_hi = hi_run;
                if (hi_run > max_hi) max_hi = hi_run;
                lo_run = 0;
                lo_bounded = 1'b1;
            end
            if (sck_o) hi_run++; else lo_run++;
            if (tgt_rst_o) begin
                rst_run++;
                lo_bounded = 1'b0;
                if (sck_o) rst_sck_clash++;
            end else if (prev_rst) begin
                if (rst_run != PULSE) bad_pulse_w++;
                rst_run = 0;
            end
            if (rsp_valid_o) begin
                rsp_cnt++;
                last_rsp = rsp_frame_o;
            end
            prev_sck = sck_o;
            prev_rst = tgt_rst_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int bad);
        @(negedge clk);
        rst_n = 1'b0;
        bad_n = bad;
        pulse_base = pulses;
        repeat (3) @(negedge clk);
        chk(tgt_rst_o == 0 && sck_o == 0, "R1", "reset tgt_rst/sck", {tgt_rst_o, sck_o}, 0);
        chk(ready_o == 0 && fail_o == 0 && req_ready_o == 0, "R1", "reset flags",
            {ready_o, fail_o, req_ready_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_outcome();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (ready_o || fail_o) break;
        end
    endtask

    task automatic test_first_try();
        int base_frm, base_rsp;
        base_frm = frm_cnt;
        base_rsp = rsp_cnt;
        do_reset(0);
        req_frame_i = 32'hDEAD_BEEF;
        req_valid_i = 1'b1;
        wait_outcome();
        req_valid_i = 1'b0;
        chk(first_rise >= SETTLE && first_rise <= SETTLE + HALF + 4, "R1",
            "cycles to first SCK rise", first_rise, SETTLE + HALF + 1);
        chk(frames[base_frm % 64] == 32'hAC53_0000, "R2", "enable frame on MOSI",
            frames[base_frm % 64], 32'hAC53_0000);
        chk(ready_o == 1 && fail_o == 0, "R4", "sync on first try", {ready_o, fail_o}, 2'b10);
        chk(pulses - pulse_base == 0, "R5", "no reset pulse when in sync", pulses - pulse_base, 0);
        chk(frm_cnt - base_frm == 1, "R7", "early request not shifted", frm_cnt - base_frm, 1);
        chk(rsp_cnt == base_rsp, "R7", "no response to early request", rsp_cnt - base_rsp, 0);
    endtask

    task automatic send_cmd(input logic [31:0] frame, input logic [31:0] exp);
        int base_frm, base_rsp;
        base_frm = frm_cnt;
        base_rsp = rsp_cnt;
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_frame_i = frame;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(req_ready_o == 0, "R7", "not ready while frame in flight", req_ready_o, 0);
        for (int i = 0; i < 1000; i++) begin
            if (rsp_cnt != base_rsp) break;
            @(negedge clk);
        end
        chk(rsp_cnt - base_rsp == 1, "R8", "one response pulse", rsp_cnt - base_rsp, 1);
        chk(last_rsp == exp, "R8", "response word", last_rsp, exp);
        chk(frames[base_frm % 64] == frame, "R8", "command frame on MOSI",
            frames[base_frm % 64], frame);
    endtask

    task automatic test_commands();
        min_hi = 1000; max_hi = 0; min_lo = 1000;
        send_cmd(32'h1234_5678, 32'h0012_3456);
        send_cmd(32'hA5C3_0F96, 32'h78A5_C30F);
        chk(min_hi == HALF && max_hi == HALF, "R3", "SCK high width", min_hi, HALF);
        chk(min_lo == HALF, "R3", "SCK low width", min_lo, HALF);
    endtask

    task automatic test_retry();
        bad_pulse_w = 0;
        rst_sck_clash = 0;
        do_reset(2);
        wait_outcome();
        chk(ready_o == 1 && fail_o == 0, "R4", "sync after retries", {ready_o, fail_o}, 2'b10);
        chk(pulses - pulse_base == 2, "R5", "reset pulse count", pulses - pulse_base, 2);
        chk(bad_pulse_w == 0, "R5", "reset pulse width errors", bad_pulse_w, 0);
        chk(rst_sck_clash == 0, "R5", "SCK high during reset pulse", rst_sck_clash, 0);
        send_cmd(32'h0F0F_3355, 32'h000F_0F33);
    endtask

    task automatic test_exhaust();
        int rises;
        do_reset(1000);
        wait_outcome();
        chk(fail_o == 1 && ready_o == 0, "R6", "fail after all attempts", {fail_o, ready_o}, 2'b10);
        chk(pulses - pulse_base == TRIES - 1, "R6", "pulses before fail",
            pulses - pulse_base, TRIES - 1);
        rises = sck_rises;
        req_valid_i = 1'b1;
        repeat (300) @(negedge clk);
        req_valid_i = 1'b0;
        chk(sck_rises == rises && !tgt_rst_o, "R6", "link quiet after fail", sck_rises - rises, 0);
        chk(fail_o == 1 && req_ready_o == 0, "R6", "fail sticky, no accept",
            {fail_o, req_ready_o}, 2'b10);
    endtask

    initial begin
        test_first_try();
        test_commands();
        test_retry();
        test_exhaust();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule